// File: doc/BRIEF.md
# Halving Complex Adder-Subtractor

This combinational unit takes two complex operands, A and B, and produces both A+B and A−B at the same time. Each real and imaginary part is a signed two's-complement word of `W` bits. Both parts of an operand are sign-extended by one bit before the operation, so the result is always exact at `W+1` bits. The unit then drops the least significant bit. Each output word therefore carries twice the weight of an input word, and its value is the true result halved and rounded toward minus infinity.

Four identical ripple-carry lanes do the work: real sum, imaginary sum, real difference and imaginary difference. A subtracting lane inverts the extended subtrahend and injects a carry of one into the same chain. Because the output is scaled down by one bit at every stage, the unit suits cascaded transform stages where the signal could otherwise grow without bound. It has no clock and holds no state.

Top module: `cplx_halfadd`

## Requirements
- R1: `sum_re` equals floor((a_re + b_re) / 2), with all words read as W-bit two's complement.
- R2: `sum_im` equals floor((a_im + b_im) / 2).
- R3: `dif_re` equals floor((a_re − b_re) / 2).
- R4: `dif_im` equals floor((a_im − b_im) / 2).
- R5: Extreme operands never wrap. With W=10: −512 + −512 gives −512, 511 + 511 gives 511, 511 − (−512) gives 511, and −512 − 511 gives −512.
- R6: The dropped bit is a truncation, not a rounding. An odd negative result rounds down (−1 + 0 gives −1), and an odd positive result rounds down (1 + 0 gives 0).
- R7: The real outputs depend only on the real inputs, and the imaginary outputs depend only on the imaginary inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_re | input | W | Real part of operand A, signed |
| a_im | input | W | Imaginary part of operand A, signed |
| b_re | input | W | Real part of operand B, signed |
| b_im | input | W | Imaginary part of operand B, signed |
| sum_re | output | W | Real part of (A+B)/2, floor |
| sum_im | output | W | Imaginary part of (A+B)/2, floor |
| dif_re | output | W | Real part of (A−B)/2, floor |
| dif_im | output | W | Imaginary part of (A−B)/2, floor |

## Verification
The bench builds the unit with the default width W=10. At that width every pair of operand words fits in a single sweep of about one million input steps. The sweep feeds the real lanes with (i, j) and the imaginary lanes with (j, i), so all four lanes see every ordered operand pair, including every carry pattern and both extremes. Directed tasks then cover the wrap-prone corners, the floor behaviour on odd results, and the separation of the real and imaginary lanes.

// File: rtl/cplx_halfadd.sv
module cplx_halfadd #(
  parameter int W = 10
) (
  input  logic [W-1:0] a_re,
  input  logic [W-1:0] a_im,
  input  logic [W-1:0] b_re,
  input  logic [W-1:0] b_im,
  output logic [W-1:0] sum_re,
  output logic [W-1:0] sum_im,
  output logic [W-1:0] dif_re,
  output logic [W-1:0] dif_im
);
  localparam int XW = W + 1;
  localparam int NL = 4;

  logic [XW-1:0] opx [NL];
  logic [XW-1:0] opy [NL];
  logic [XW-1:0] res [NL];

  assign opx[0] = {a_re[W-1], a_re};
  assign opx[1] = {a_im[W-1], a_im};
  assign opx[2] = {a_re[W-1], a_re};
  assign opx[3] = {a_im[W-1], a_im};
  assign opy[0] = {b_re[W-1], b_re};
  assign opy[1] = {b_im[W-1], b_im};
  assign opy[2] = {b_re[W-1], b_re};
  assign opy[3] = {b_im[W-1], b_im};

  for (genvar l = 0; l < NL; l++) begin : g_lane
    localparam bit SUB = (l >= 2);
    logic [XW-1:0] yy;
    logic [XW-1:0] c;
    logic [XW-1:0] s;

    assign yy   = SUB ? ~opy[l] : opy[l];
    assign c[0] = SUB;

    for (genvar b = 0; b < XW; b++) begin : g_fa
      assign s[b] = opx[l][b] ^ yy[b] ^ c[b];
      if (b < XW - 1) begin : g_cy
        assign c[b+1] = (opx[l][b] & yy[b]) | (c[b] & (opx[l][b] ^ yy[b]));
      end
    end

    assign res[l] = s;

    always_comb begin
      if (!$isunknown({opx[l][0], opy[l][0]}))
        AST_DROP_PARITY: assert (res[l][0] == (opx[l][0] ^ opy[l][0])); // R6
    end
  end

  assign sum_re = res[0][XW-1:1];
  assign sum_im = res[1][XW-1:1];
  assign dif_re = res[2][XW-1:1];
  assign dif_im = res[3][XW-1:1];

  logic signed [XW-1:0] ref_sr, ref_si, ref_dr, ref_di;

  always_comb begin
    ref_sr = $signed({a_re[W-1], a_re}) + $signed({b_re[W-1], b_re});
    ref_si = $signed({a_im[W-1], a_im}) + $signed({b_im[W-1], b_im});
    ref_dr = $signed({a_re[W-1], a_re}) - $signed({b_re[W-1], b_re});
    ref_di = $signed({a_im[W-1], a_im}) - $signed({b_im[W-1], b_im});
    if (!$isunknown({a_re, a_im, b_re, b_im})) begin
      AST_SUM_RE: assert (sum_re == ref_sr[XW-1:1]); // R1
      AST_SUM_IM: assert (sum_im == ref_si[XW-1:1]); // R2
      AST_DIF_RE: assert (dif_re == ref_dr[XW-1:1]); // R3
      AST_DIF_IM: assert (dif_im == ref_di[XW-1:1]); // R4
      AST_NO_OVERFLOW: assert ((sum_re[W-1] == ref_sr[XW-1]) && (dif_re[W-1] == ref_dr[XW-1])); // R5
    end
  end
endmodule

// File: tb/sim_cplx_halfadd.sv
module sim_cplx_halfadd;
  localparam int W = 10;
  localparam int CLK_PERIOD = 10;
  localparam int LO = -(1 << (W - 1));
  localparam int HI = (1 << (W - 1)) - 1;

  logic clk = 1'b0;
  logic [W-1:0] a_re, a_im, b_re, b_im;
  logic [W-1:0] sum_re, sum_im, dif_re, dif_im;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cplx_halfadd #(.W(W)) u0 (
    .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
    .sum_re(sum_re), .sum_im(sum_im), .dif_re(dif_re), .dif_im(dif_im)
  );

  function automatic int half_floor(int x);
    return x >>> 1;
  endfunction

  function automatic int sv(logic [W-1:0] v);
    return int'($signed(v));
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(int ar, int ai, int br, int bi);
    a_re = W'(ar); a_im = W'(ai); b_re = W'(br); b_im = W'(bi);
    #1;
  endtask

  task automatic chk_all(int ar, int ai, int br, int bi);
    chk("R1", sv(sum_re), half_floor(ar + br));
    chk("R2", sv(sum_im), half_floor(ai + bi));
    chk("R3", sv(dif_re), half_floor(ar - br));
    chk("R4", sv(dif_im), half_floor(ai - bi));
  endtask

  task automatic t_zero();
    @(negedge clk);
    drive(0, 0, 0, 0);
    chk_all(0, 0, 0, 0);
  endtask

  task automatic t_sweep();
    for (int i = LO; i <= HI; i++) begin
      for (int j = LO; j <= HI; j++) begin
        drive(i, j, j, i);
        chk_all(i, j, j, i);
      end
    end
  endtask

  task automatic t_extremes();
    @(negedge clk);
    drive(LO, HI, LO, HI);
    chk("R5", sv(sum_re), LO);
    chk("R5", sv(sum_im), HI);
    @(negedge clk);
    drive(HI, LO, LO, HI);
    chk("R5", sv(dif_re), HI);
    chk("R5", sv(dif_im), LO);
  endtask

  task automatic t_floor();
    @(negedge clk);
    drive(-1, 1, 0, 0);
    chk("R6", sv(sum_re), -1);
    chk("R6", sv(sum_im), 0);
    chk("R6", sv(dif_re), -1);
    chk("R6", sv(dif_im), 0);
    @(negedge clk);
    drive(2, -3, 5, 4);
    chk("R6", sv(dif_re), -2);
    chk("R6", sv(sum_im), 0);
  endtask

  task automatic t_isolation();
    @(negedge clk);
    drive(100, 0, -37, 0);
    chk("R7", sv(sum_re), 31);
    chk("R7", sv(dif_re), 68);
    drive(100, HI, -37, LO);
    chk("R7", sv(sum_re), 31);
    chk("R7", sv(dif_re), 68);
    drive(0, 77, 0, 22);
    chk("R7", sv(sum_im), 49);
    drive(LO, 77, HI, 22);
    chk("R7", sv(sum_im), 49);
    chk("R7", sv(dif_im), 27);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_zero();
    t_extremes();
    t_floor();
    t_isolation();
    t_sweep();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule